// File: doc/BRIEF.md
# Image Command Dispatch and Busy Controller

This block is the register-mapped front end of a command-driven image processing unit. A 32-bit write to the command register is split into a 4-bit opcode and a 28-bit argument. Two opcodes finish on the spot: one clears the bitstream input and one loads colour thresholds. Both raise the interrupt and never show busy. Every other legal opcode is passed to a worker engine through a one-cycle start pulse. The block then holds its busy flags until the engine reports done. At that point it captures the engine's results and raises the interrupt.

A control/status register holds the decoder mode bits and a soft-reset trigger. It also carries the sticky error, end-of-data and start-code flags. When it is read, the input FIFO fill level and the stored coded block pattern are merged into the word. Addresses decode only the low window bits, so the whole register set repeats through the page.

Top module: `imgcmd_dispatch`

## Requirements
- R1: After reset, every register reads zero except the FIFO level field, the interrupt, start, skip, flush and bit-pointer-load pulses are low, and the thresholds are zero.
- R2: Every accepted command write clears the end-of-data flag (control bit 24) and the start-code flag (control bit 25).
- R3: Opcode 0 (clear) and opcode 9 (threshold) complete in the write cycle: the next cycle has a one-cycle `irq`, and busy (control bit 31) stays 0. Clear pulses `fifo_flush` and `bp_load` with `bp_value` = command bits 6:0. Threshold loads `thr_lo` from bits 7:0 and `thr_hi` from bits 23:16.
- R4: Opcodes 1 to 8 set busy and give a one-cycle `eng_start`, with `eng_op` = bits 31:28 and `eng_arg` = bits 27:0. On the first `eng_done` seen while busy, busy clears and a one-cycle `irq` follows.
- R5: Opcodes 1 to 4 also set the command-busy flag (bit 0 of the word at offset 0x04). It clears at the same `eng_done`. Opcodes 5 to 8 leave it 0.
- R6: Opcodes 1 to 5 pulse `skip_valid` together with `eng_start`, carrying command bits 5:0 on `skip_bits`. Opcodes 6 to 8 do not pulse it.
- R7: A command write that arrives while busy, or that carries opcode 10 to 15, is ignored: no start, no interrupt, no flag or threshold change. It sets the sticky error flag (control bit 26).
- R8: A control write (offset 0x10) loads bits 17:16 as the DC precision field and bits 23:18 as mode bits. A written precision of 3 is stored as 1.
- R9: A control write with bit 30 set does the following: it clears busy, command-busy, the error, end-of-data and start-code flags, the coded block pattern and the top-data register. It pulses `fifo_flush`, and pulses `bp_load` with value 0. A later `eng_done` then has no effect.
- R10: Reads and writes decode only address bits 7:0. The offsets are 0x00 (command write / result read), 0x04 (command status), 0x10 (control) and 0x30 (top data). Other offsets read zero.
- R11: At done, opcodes 3 and 4 copy `eng_result` to the result register (0x00) and `eng_top` to the top-data register (0x30). Opcode 3 then sets end-of-data exactly when `eng_result` is zero.
- R12: A control read returns `fifo_level` in bits 11:8 and the coded block pattern in bits 5:0. The pattern is taken from `eng_cbp` when an opcode 2 command completes.
- R13: At every engine completion, the start-code flag takes the value of `eng_sc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| fifo_level | input | 4 | Input FIFO fill level, merged into control reads |
| eng_start | output | 1 | One-cycle start to the worker engines |
| eng_op | output | 4 | Opcode of the last started command |
| eng_arg | output | 28 | Argument bits of the last started command |
| eng_done | input | 1 | Worker completion strobe |
| eng_result | input | 32 | Result word returned by the worker |
| eng_top | input | 32 | Next bitstream word returned by the worker |
| eng_sc | input | 1 | Start code seen by the worker |
| eng_cbp | input | 6 | Coded block pattern from a block decode |
| skip_valid | output | 1 | Bit-skip request to the bitstream unit |
| skip_bits | output | 6 | Number of bits to skip |
| bp_load | output | 1 | Load the bit pointer |
| bp_value | output | 7 | Bit pointer value to load |
| fifo_flush | output | 1 | Flush pulse to the FIFOs |
| thr_lo | output | 8 | Lower colour threshold |
| thr_hi | output | 8 | Upper colour threshold |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
A busy flag that stays set wrongly would show up at the very next command write. The write would then fail to start, and the error bit would appear in the control word one cycle later. A busy flag that drops early would let a second start through. A wrong captured command class would put the wrong value at offset 0x00, 0x30 or in the coded block pattern field, or a wrong end-of-data bit, in the cycle right after `eng_done`. The read mux is combinational, so every stored flag can be seen in the same cycle through any aliased address. The bench compares all of these against its model on every clock.

// File: rtl/imgcmd_pkg.sv
package imgcmd_pkg;

   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_CLR   = 4'd0,
      OP_PDEC  = 4'd1,
      OP_BDEC  = 4'd2,
      OP_FLD   = 4'd3,
      OP_FETCH = 4'd4,
      OP_QMAT  = 4'd5,
      OP_PAL   = 4'd6,
      OP_CONV  = 4'd7,
      OP_PACK  = 4'd8,
      OP_THR   = 4'd9
   } op_e;

   // register offsets inside the window
   localparam int OFS_CMD  = 'h00;
   localparam int OFS_STAT = 'h04;
   localparam int OFS_CTRL = 'h10;
   localparam int OFS_TOP  = 'h30;

   // control word bit positions
   localparam int CB_BUSY = 31;
   localparam int CB_SRST = 30;
   localparam int CB_ERR  = 26;
   localparam int CB_SCD  = 25;
   localparam int CB_EOD  = 24;
   localparam int CB_MODE = 18;
   localparam int CB_PREC = 16;
   localparam int CB_FIFO = 8;
   localparam int CB_CBP  = 0;
   localparam int MODE_W  = 6;

   typedef struct packed {
      logic legal;
      logic immed;
      logic data_busy;
      logic skips;
      logic gives_data;
      logic sets_eod;
      logic gives_cbp;
   } op_class_t;

   function automatic op_class_t classify(input logic [OP_W-1:0] op);
      op_class_t c;
      c = '0;
      case (op)
         OP_CLR, OP_THR: begin
            c.legal = 1'b1;
            c.immed = 1'b1;
         end
         OP_PDEC, OP_BDEC, OP_FLD, OP_FETCH: begin
            c.legal     = 1'b1;
            c.data_busy = 1'b1;
            c.skips     = 1'b1;
            c.gives_data = (op == OP_FLD) || (op == OP_FETCH);
            c.sets_eod  = (op == OP_FLD);
            c.gives_cbp = (op == OP_BDEC);
         end
         OP_QMAT: begin
            c.legal = 1'b1;
            c.skips = 1'b1;
         end
         OP_PAL, OP_CONV, OP_PACK: c.legal = 1'b1;
         default: c = '0;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/imgcmd_decode.sv
module imgcmd_decode
   import imgcmd_pkg::*;
#(
   parameter int ADDR_W       = 12,
   parameter int WIN_W        = 8,
   parameter bit ALIAS_WRITES = 1'b1
) (
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [OP_W-1:0]   op_field,
   output logic              cmd_wr,
   output logic              ctrl_wr,
   output logic [OP_W-1:0]   op,
   output op_class_t         cls,
   output logic [WIN_W-1:0]  win_ofs
);

   localparam int NUM_OPS = 1 << OP_W;

   op_class_t cls_tbl [NUM_OPS];
   logic      page_ok;

   for (genvar g = 0; g < NUM_OPS; g++) begin : g_tbl
      assign cls_tbl[g] = classify(OP_W'(g));
   end

   if (ALIAS_WRITES) begin : g_alias
      logic unused_page;
      assign unused_page = ^bus_addr[ADDR_W-1:WIN_W];
      assign page_ok     = 1'b1;
   end else begin : g_strict
      assign page_ok = (bus_addr[ADDR_W-1:WIN_W] == '0);
   end

   assign win_ofs = bus_addr[WIN_W-1:0];
   assign op      = op_field;
   assign cls     = cls_tbl[op_field];
   assign cmd_wr  = bus_wr && page_ok && (win_ofs == WIN_W'(OFS_CMD));
   assign ctrl_wr = bus_wr && page_ok && (win_ofs == WIN_W'(OFS_CTRL));

endmodule

// File: rtl/imgcmd_mode_reg.sv
module imgcmd_mode_reg
   import imgcmd_pkg::*;
#(
   parameter int PREC_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic              rst_bit,
   input  logic [PREC_W-1:0] prec_in,
   input  logic [MODE_W-1:0] mode_in,
   output logic [PREC_W-1:0] prec,
   output logic [MODE_W-1:0] mode,
   output logic              soft_rst
);

   localparam logic [PREC_W-1:0] PREC_BAD = '1;
   localparam logic [PREC_W-1:0] PREC_FIX = PREC_W'(1);

   assign soft_rst = ctrl_wr && rst_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prec <= '0;
         mode <= '0;
      end else if (ctrl_wr) begin
         prec <= (prec_in == PREC_BAD) ? PREC_FIX : prec_in;
         mode <= mode_in;
      end
   end

endmodule

// File: rtl/imgcmd_seq.sv
module imgcmd_seq
   import imgcmd_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CBP_W  = 6,
   parameter int SKIP_W = 6,
   parameter int BP_W   = 7,
   parameter int THR_W  = 8,
   parameter int THR_HI = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_wr,
   input  logic [OP_W-1:0]      op,
   input  op_class_t            cls,
   input  logic [DATA_W-OP_W-1:0] arg,
   input  logic                 soft_rst,
   input  logic                 eng_done,
   input  logic [DATA_W-1:0]    eng_result,
   input  logic [DATA_W-1:0]    eng_top,
   input  logic                 eng_sc,
   input  logic [CBP_W-1:0]     eng_cbp,
   output logic                 busy,
   output logic                 dbusy,
   output logic                 err,
   output logic                 eod,
   output logic                 scd,
   output logic [CBP_W-1:0]     cbp,
   output logic [DATA_W-1:0]    res_q,
   output logic [DATA_W-1:0]    top_q,
   output logic                 irq,
   output logic                 eng_start,
   output logic [OP_W-1:0]      eng_op,
   output logic [DATA_W-OP_W-1:0] eng_arg,
   output logic                 skip_valid,
   output logic [SKIP_W-1:0]    skip_bits,
   output logic                 bp_load,
   output logic [BP_W-1:0]      bp_value,
   output logic                 fifo_flush,
   output logic [THR_W-1:0]     thr_lo,
   output logic [THR_W-1:0]     thr_hi
);

   logic accept, reject, done_ok;
   logic cur_data, cur_eod, cur_cbp;

   assign accept  = cmd_wr && !busy && cls.legal;
   assign reject  = cmd_wr && (busy || !cls.legal);
   assign done_ok = busy && eng_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         dbusy      <= 1'b0;
         err        <= 1'b0;
         eod        <= 1'b0;
         scd        <= 1'b0;
         cbp        <= '0;
         res_q      <= '0;
         top_q      <= '0;
         irq        <= 1'b0;
         eng_start  <= 1'b0;
         eng_op     <= '0;
         eng_arg    <= '0;
         skip_valid <= 1'b0;
         skip_bits  <= '0;
         bp_load    <= 1'b0;
         bp_value   <= '0;
         fifo_flush <= 1'b0;
         thr_lo     <= '0;
         thr_hi     <= '0;
         cur_data   <= 1'b0;
         cur_eod    <= 1'b0;
         cur_cbp    <= 1'b0;
      end else begin
         irq        <= 1'b0;
         eng_start  <= 1'b0;
         skip_valid <= 1'b0;
         bp_load    <= 1'b0;
         fifo_flush <= 1'b0;
         if (soft_rst) begin
            busy       <= 1'b0;
            dbusy      <= 1'b0;
            err        <= 1'b0;
            eod        <= 1'b0;
            scd        <= 1'b0;
            cbp        <= '0;
            top_q      <= '0;
            fifo_flush <= 1'b1;
            bp_load    <= 1'b1;
            bp_value   <= '0;
         end else begin
            if (done_ok) begin
               busy  <= 1'b0;
               dbusy <= 1'b0;
               irq   <= 1'b1;
               scd   <= eng_sc;
               if (cur_data) begin
                  res_q <= eng_result;
                  top_q <= eng_top;
               end
               if (cur_eod) eod <= (eng_result == '0);
               if (cur_cbp) cbp <= eng_cbp;
            end
            if (reject) err <= 1'b1;
            if (accept) begin
               eod <= 1'b0;
               scd <= 1'b0;
               if (cls.immed) begin
                  irq <= 1'b1;
                  if (op == OP_CLR) begin
                     fifo_flush <= 1'b1;
                     bp_load    <= 1'b1;
                     bp_value   <= arg[BP_W-1:0];
                  end else begin
                     thr_lo <= arg[THR_W-1:0];
                     thr_hi <= arg[THR_HI +: THR_W];
                  end
               end else begin
                  busy       <= 1'b1;
                  dbusy      <= cls.data_busy;
                  eng_start  <= 1'b1;
                  eng_op     <= op;
                  eng_arg    <= arg;
                  skip_valid <= cls.skips;
                  skip_bits  <= arg[SKIP_W-1:0];
                  cur_data   <= cls.gives_data;
                  cur_eod    <= cls.sets_eod;
                  cur_cbp    <= cls.gives_cbp;
               end
            end
         end
      end
   end

endmodule

// File: rtl/imgcmd_dispatch.sv
module imgcmd_dispatch
   import imgcmd_pkg::*;
#(
   parameter int ADDR_W       = 12,
   parameter int WIN_W        = 8,
   parameter int DATA_W       = 32,
   parameter int FIFO_W       = 4,
   parameter int CBP_W        = 6,
   parameter int SKIP_W       = 6,
   parameter int BP_W         = 7,
   parameter int THR_W        = 8,
   parameter bit ALIAS_WRITES = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_wr,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [DATA_W-1:0]        bus_wdata,
   output logic [DATA_W-1:0]        bus_rdata,
   input  logic [FIFO_W-1:0]        fifo_level,
   output logic                     eng_start,
   output logic [OP_W-1:0]          eng_op,
   output logic [DATA_W-OP_W-1:0]   eng_arg,
   input  logic                     eng_done,
   input  logic [DATA_W-1:0]        eng_result,
   input  logic [DATA_W-1:0]        eng_top,
   input  logic                     eng_sc,
   input  logic [CBP_W-1:0]         eng_cbp,
   output logic                     skip_valid,
   output logic [SKIP_W-1:0]        skip_bits,
   output logic                     bp_load,
   output logic [BP_W-1:0]          bp_value,
   output logic                     fifo_flush,
   output logic [THR_W-1:0]         thr_lo,
   output logic [THR_W-1:0]         thr_hi,
   output logic                     irq
);

   localparam int PREC_W = 2;
   localparam int ARG_W  = DATA_W - OP_W;
   localparam int THR_HI = 16;

   if (DATA_W != 32) begin : g_bad_data
      $error("imgcmd_dispatch: DATA_W must be 32");
   end
   if (WIN_W < 6 || WIN_W >= ADDR_W) begin : g_bad_win
      $error("imgcmd_dispatch: WIN_W must be at least 6 and below ADDR_W");
   end
   if (FIFO_W < 1 || FIFO_W > 4) begin : g_bad_fifo
      $error("imgcmd_dispatch: FIFO_W must be 1 to 4");
   end
   if (CBP_W < 1 || CBP_W > 6) begin : g_bad_cbp
      $error("imgcmd_dispatch: CBP_W must be 1 to 6");
   end
   if (SKIP_W < 1 || SKIP_W > 6 || BP_W < 1 || BP_W > 7) begin : g_bad_bp
      $error("imgcmd_dispatch: skip or bit pointer width out of range");
   end
   if (THR_W < 1 || THR_W > 8) begin : g_bad_thr
      $error("imgcmd_dispatch: THR_W must be 1 to 8");
   end

   logic              cmd_wr, ctrl_wr, soft_rst;
   logic [OP_W-1:0]   cmd_op;
   op_class_t         cmd_cls;
   logic [WIN_W-1:0]  win_ofs;
   logic [PREC_W-1:0] prec;
   logic [MODE_W-1:0] mode;
   logic              busy, dbusy, err, eod, scd;
   logic [CBP_W-1:0]  cbp;
   logic [DATA_W-1:0] res_q, top_q, ctrl_word;

   imgcmd_decode #(
      .ADDR_W      (ADDR_W),
      .WIN_W       (WIN_W),
      .ALIAS_WRITES(ALIAS_WRITES)
   ) u_decode (
      .bus_wr  (bus_wr),
      .bus_addr(bus_addr),
      .op_field(bus_wdata[DATA_W-1 -: OP_W]),
      .cmd_wr  (cmd_wr),
      .ctrl_wr (ctrl_wr),
      .op      (cmd_op),
      .cls     (cmd_cls),
      .win_ofs (win_ofs)
   );

   imgcmd_mode_reg #(
      .PREC_W(PREC_W)
   ) u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl_wr (ctrl_wr),
      .rst_bit (bus_wdata[CB_SRST]),
      .prec_in (bus_wdata[CB_PREC +: PREC_W]),
      .mode_in (bus_wdata[CB_MODE +: MODE_W]),
      .prec    (prec),
      .mode    (mode),
      .soft_rst(soft_rst)
   );

   imgcmd_seq #(
      .DATA_W(DATA_W),
      .CBP_W (CBP_W),
      .SKIP_W(SKIP_W),
      .BP_W  (BP_W),
      .THR_W (THR_W),
      .THR_HI(THR_HI)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_wr    (cmd_wr),
      .op        (cmd_op),
      .cls       (cmd_cls),
      .arg       (bus_wdata[ARG_W-1:0]),
      .soft_rst  (soft_rst),
      .eng_done  (eng_done),
      .eng_result(eng_result),
      .eng_top   (eng_top),
      .eng_sc    (eng_sc),
      .eng_cbp   (eng_cbp),
      .busy      (busy),
      .dbusy     (dbusy),
      .err       (err),
      .eod       (eod),
      .scd       (scd),
      .cbp       (cbp),
      .res_q     (res_q),
      .top_q     (top_q),
      .irq       (irq),
      .eng_start (eng_start),
      .eng_op    (eng_op),
      .eng_arg   (eng_arg),
      .skip_valid(skip_valid),
      .skip_bits (skip_bits),
      .bp_load   (bp_load),
      .bp_value  (bp_value),
      .fifo_flush(fifo_flush),
      .thr_lo    (thr_lo),
      .thr_hi    (thr_hi)
   );

   always_comb begin
      ctrl_word                       = '0;
      ctrl_word[CB_BUSY]              = busy;
      ctrl_word[CB_ERR]               = err;
      ctrl_word[CB_SCD]               = scd;
      ctrl_word[CB_EOD]               = eod;
      ctrl_word[CB_MODE +: MODE_W]    = mode;
      ctrl_word[CB_PREC +: PREC_W]    = prec;
      ctrl_word[CB_FIFO +: FIFO_W]    = fifo_level;
      ctrl_word[CB_CBP +: CBP_W]      = cbp;
   end

   always_comb begin
      case (win_ofs)
         WIN_W'(OFS_CMD):  bus_rdata = res_q;
         WIN_W'(OFS_STAT): bus_rdata = DATA_W'(dbusy);
         WIN_W'(OFS_CTRL): bus_rdata = ctrl_word;
         WIN_W'(OFS_TOP):  bus_rdata = top_q;
         default:          bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/imgcmd_dispatch_chk.sv
module imgcmd_dispatch_chk
   import imgcmd_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_wr,
   input op_class_t  cls,
   input logic       ctrl_wr,
   input logic [1:0] wprec,
   input logic [1:0] prec,
   input logic       busy,
   input logic       dbusy,
   input logic       err,
   input logic       eng_start,
   input logic       eng_done,
   input logic       skip_valid,
   input logic       irq,
   input logic       soft_rst,
   input logic       fifo_flush
);

   // R3: immediate opcodes interrupt next cycle and stay idle
   p_imm_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr && !busy && cls.immed |=> irq && !busy);

   // R4: a start pulse is only seen while busy
   p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> busy);

   // R4: completion drops busy and interrupts
   p_done_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy && eng_done && !soft_rst |=> !busy && irq);

   // R5: command-busy never outlives control busy
   p_dbusy_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dbusy |-> busy);

   // R6: skip requests travel with a start
   p_skip_with_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      skip_valid |-> eng_start);

   // R7: a write while busy starts nothing and flags an error
   p_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr && busy && !eng_done |=> err && !eng_start && busy);

   // R8: precision 3 is corrected to 1
   p_prec_fix_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr && (wprec == 2'b11) |=> prec == 2'b01);

   // R9: soft reset idles the block and flushes
   p_soft_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !busy && !dbusy && !err && fifo_flush);

endmodule

bind imgcmd_dispatch imgcmd_dispatch_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_wr    (cmd_wr),
   .cls       (cmd_cls),
   .ctrl_wr   (ctrl_wr),
   .wprec     (bus_wdata[17:16]),
   .prec      (prec),
   .busy      (busy),
   .dbusy     (dbusy),
   .err       (err),
   .eng_start (eng_start),
   .eng_done  (eng_done),
   .skip_valid(skip_valid),
   .irq       (irq),
   .soft_rst  (soft_rst),
   .fifo_flush(fifo_flush)
);

// File: tb/imgcmd_dispatch_bench.sv
`timescale 1ns/1ps
module imgcmd_dispatch_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        b_wr = 1'b0;
   logic [11:0] b_addr = '0;
   logic [31:0] b_wdata = '0;
   logic [31:0] rdata;
   logic [3:0]  lvl = 4'h0;
   logic        e_start, e_done = 1'b0, e_sc = 1'b0;
   logic [3:0]  e_op;
   logic [27:0] e_arg;
   logic [31:0] e_result = '0, e_top = '0;
   logic [5:0]  e_cbp = '0;
   logic        s_valid, s_bpl, s_flush, s_irq;
   logic [5:0]  s_bits;
   logic [6:0]  s_bpv;
   logic [7:0]  s_tlo, s_thi;

   always #2 clk = ~clk;

   imgcmd_dispatch u_imgcmd_dispatch (
      .clk(clk), .rst_n(rst_n), .bus_wr(b_wr), .bus_addr(b_addr),
      .bus_wdata(b_wdata), .bus_rdata(rdata), .fifo_level(lvl),
      .eng_start(e_start), .eng_op(e_op), .eng_arg(e_arg),
      .eng_done(e_done), .eng_result(e_result), .eng_top(e_top),
      .eng_sc(e_sc), .eng_cbp(e_cbp), .skip_valid(s_valid),
      .skip_bits(s_bits), .bp_load(s_bpl), .bp_value(s_bpv),
      .fifo_flush(s_flush), .thr_lo(s_tlo), .thr_hi(s_thi), .irq(s_irq)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    finished = 1'b0;
   string cur_tag = "R1";

   // reference model state
   bit        m_busy, m_dbusy, m_err, m_eod, m_scd;
   bit [5:0]  m_cbp, m_mode;
   bit [1:0]  m_prec;
   bit [31:0] m_res, m_top;
   bit        m_irq, m_start, m_skipv, m_bpl, m_flush;
   bit [3:0]  m_op;
   bit [27:0] m_arg;
   bit [5:0]  m_skipb;
   bit [6:0]  m_bpv;
   bit [7:0]  m_tlo, m_thi;
   int        m_cur;
   bit        was_busy, cw, kw, dn;
   int        opv;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_dbusy = 0; m_err = 0; m_eod = 0; m_scd = 0;
         m_cbp = 0; m_mode = 0; m_prec = 0; m_res = 0; m_top = 0;
         m_irq = 0; m_start = 0; m_skipv = 0; m_bpl = 0; m_flush = 0;
         m_op = 0; m_arg = 0; m_skipb = 0; m_bpv = 0; m_tlo = 0; m_thi = 0;
         m_cur = 0;
      end else begin
         m_irq = 0; m_start = 0; m_skipv = 0; m_bpl = 0; m_flush = 0;
         cw = b_wr && (b_addr[7:0] == 8'h00);
         kw = b_wr && (b_addr[7:0] == 8'h10);
         was_busy = m_busy;
         dn = m_busy && e_done;
         if (kw && b_wdata[30]) begin
            m_busy = 0; m_dbusy = 0; m_err = 0; m_eod = 0; m_scd = 0;
            m_cbp = 0; m_top = 0; m_flush = 1; m_bpl = 1; m_bpv = 0;
         end else begin
            if (dn) begin
               m_busy = 0; m_dbusy = 0; m_irq = 1; m_scd = e_sc;
               if (m_cur == 3 || m_cur == 4) begin m_res = e_result; m_top = e_top; end
               if (m_cur == 3) m_eod = (e_result == 0);
               if (m_cur == 2) m_cbp = e_cbp;
            end
            if (cw) begin
               opv = int'(b_wdata[31:28]);
               if (was_busy || opv > 9) m_err = 1;
               else begin
                  m_eod = 0; m_scd = 0;
                  if (opv == 0) begin
                     m_irq = 1; m_flush = 1; m_bpl = 1; m_bpv = b_wdata[6:0];
                  end else if (opv == 9) begin
                     m_irq = 1; m_tlo = b_wdata[7:0]; m_thi = b_wdata[23:16];
                  end else begin
                     m_busy = 1; m_dbusy = (opv <= 4); m_start = 1;
                     m_op = b_wdata[31:28]; m_arg = b_wdata[27:0]; m_cur = opv;
                     m_skipv = (opv <= 5); m_skipb = b_wdata[5:0];
                  end
               end
            end
         end
         if (kw) begin
            m_prec = (b_wdata[17:16] == 2'b11) ? 2'b01 : b_wdata[17:16];
            m_mode = b_wdata[23:18];
         end
      end
   end

   function automatic logic [31:0] exp_read(input logic [11:0] a);
      case (a[7:0])
         8'h00: return m_res;
         8'h04: return {31'b0, m_dbusy};
         8'h10: return {m_busy, 4'b0, m_err, m_scd, m_eod, m_mode, m_prec,
                        4'b0, lvl, 2'b0, m_cbp};
         8'h30: return m_top;
         default: return 32'h0;
      endcase
   endfunction

   task automatic chk(input string nm, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h at %0t", cur_tag, nm, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!finished) begin
         chk("rdata", rdata, exp_read(b_addr));
         chk("irq", 32'(s_irq), 32'(m_irq));
         chk("eng_start", 32'(e_start), 32'(m_start));
         chk("eng_op", 32'(e_op), 32'(m_op));
         chk("eng_arg", 32'(e_arg), 32'(m_arg));
         chk("skip_valid", 32'(s_valid), 32'(m_skipv));
         chk("skip_bits", 32'(s_bits), 32'(m_skipb));
         chk("bp_load", 32'(s_bpl), 32'(m_bpl));
         chk("bp_value", 32'(s_bpv), 32'(m_bpv));
         chk("fifo_flush", 32'(s_flush), 32'(m_flush));
         chk("thr_lo", 32'(s_tlo), 32'(m_tlo));
         chk("thr_hi", 32'(s_thi), 32'(m_thi));
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      b_wr = 1'b1; b_addr = a; b_wdata = d;
      cyc(1);
      b_wr = 1'b0;
   endtask

   task automatic done(input logic [31:0] r, input logic [31:0] t,
                       input logic sc, input logic [5:0] cb);
      e_done = 1'b1; e_result = r; e_top = t; e_sc = sc; e_cbp = cb;
      cyc(1);
      e_done = 1'b0;
   endtask

   task automatic lit(input string nm, input logic [31:0] act, input logic [31:0] exp);
      #0.5;
      chk(nm, act, exp);
   endtask

   task automatic summary;
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (30000) @(posedge clk);
      cur_tag = "watchdog";
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
   end

   initial begin
      // R1 reset state
      cur_tag = "R1";
      cyc(3);
      rst_n = 1'b1;
      lvl = 4'h5;
      b_addr = 12'h010; cyc(1);
      lit("ctrl after reset", rdata, 32'h0000_0500);
      b_addr = 12'h000; cyc(1);
      b_addr = 12'h004; cyc(1);
      b_addr = 12'h030; cyc(1);

      // R3 immediate threshold and clear
      cur_tag = "R3";
      wr(12'h000, 32'h90AB_00CD);
      lit("thr_lo", 32'(s_tlo), 32'hCD);
      lit("irq thr", 32'(s_irq), 32'h1);
      b_addr = 12'h010; cyc(1);
      wr(12'h000, 32'h0000_00D5);
      lit("bp_value clr", 32'(s_bpv), 32'h55);
      cyc(2);

      // R4 R5 R6 long decode with skip
      cur_tag = "R4";
      wr(12'h000, 32'h1123_452A);
      lit("eng_start", 32'(e_start), 32'h1);
      cur_tag = "R5";
      b_addr = 12'h004; cyc(2);
      cur_tag = "R7";
      wr(12'h000, 32'h9000_0077);
      b_addr = 12'h010; cyc(1);
      lit("err bit", rdata & 32'h0400_0000, 32'h0400_0000);
      cur_tag = "R4";
      done(32'h1234, 32'h5678, 1'b0, 6'h3F);
      lit("irq at done", 32'(s_irq), 32'h1);
      b_addr = 12'h004; cyc(2);

      // R9 soft reset while busy, late done ignored
      cur_tag = "R9";
      wr(12'h000, 32'h7000_0001);
      b_addr = 12'h010; cyc(2);
      wr(12'h010, 32'h4000_0000);
      cyc(2);
      done(32'h0, 32'h0, 1'b1, 6'h01);
      cyc(2);

      // R7 undefined opcode
      cur_tag = "R7";
      wr(12'h000, 32'hB000_0003);
      cyc(1);
      wr(12'h010, 32'h4000_0000);

      // R11 R2 field decode returning zero
      cur_tag = "R11";
      wr(12'h000, 32'h3000_0011);
      cyc(3);
      done(32'h0, 32'hCAFE_F00D, 1'b0, 6'h0);
      b_addr = 12'h010; cyc(1);
      lit("eod set", rdata & 32'h0100_0000, 32'h0100_0000);
      b_addr = 12'h030; cyc(1);
      b_addr = 12'h000; cyc(1);
      cur_tag = "R2";
      wr(12'h000, 32'h9000_0000);
      b_addr = 12'h010; cyc(1);

      // R13 R11 fetch with start code, nonzero result
      cur_tag = "R13";
      wr(12'h000, 32'h4000_0020);
      cyc(1);
      done(32'hDEAD_0001, 32'h0BAD_BEEF, 1'b1, 6'h0);
      cyc(1);
      cur_tag = "R11";
      b_addr = 12'h000; cyc(1);
      b_addr = 12'h030; cyc(1);
      cur_tag = "R2";
      b_addr = 12'h010;
      wr(12'h000, 32'h0000_0000);
      b_addr = 12'h010; cyc(1);

      // R12 block decode pattern and FIFO level merge
      cur_tag = "R12";
      wr(12'h000, 32'h2000_0005);
      b_addr = 12'h010;
      cyc(2);
      lvl = 4'hA;
      done(32'h1, 32'h2, 1'b0, 6'h2D);
      cyc(1);
      lit("cbp merged", rdata & 32'h0000_0F3F, 32'h0000_0A2D);

      // R6 skip on 5, none on 6, 8
      cur_tag = "R6";
      wr(12'h000, 32'h5000_0013);
      b_addr = 12'h004; cyc(2);
      done(32'h0, 32'h0, 1'b0, 6'h0);
      wr(12'h000, 32'h6000_0013);
      lit("no skip op6", 32'(s_valid), 32'h0);
      cyc(1);
      done(32'h0, 32'h0, 1'b0, 6'h0);
      wr(12'h000, 32'h8FFF_FFFF);
      cyc(1);
      done(32'h0, 32'h0, 1'b0, 6'h0);
      cyc(1);

      // R8 precision correction and mode bits
      cur_tag = "R8";
      wr(12'h010, 32'h00FF_0000);
      b_addr = 12'h010; cyc(1);
      lit("prec fixed", (rdata >> 16) & 32'h3, 32'h1);
      wr(12'h010, 32'h0056_0000);
      b_addr = 12'h010; cyc(1);

      // R10 aliasing through the page
      cur_tag = "R10";
      wr(12'h300, 32'h9011_0022);
      b_addr = 12'h510; cyc(1);
      wr(12'hF10, 32'h0001_0000);
      b_addr = 12'hA10; cyc(1);
      b_addr = 12'h020; cyc(1);
      b_addr = 12'h730; cyc(1);

      cyc(2);
      summary();
   end

endmodule